// File: doc/BRIEF.md
# Five-Port Micro-Op Dispatch Scheduler

This block is the waiting room between rename and execution. Renamed micro-ops are written into a small pool of entries, together with a class code and two source tags that each carry a ready flag. Result tags broadcast on the wakeup buses mark matching sources as ready. An entry whose two sources are both ready competes for the execution port its class is allowed to use. Each port then takes the oldest such entry.

There are five ports, and they are not equal. Port 0 is shared by full-function integer work (shift, multiply, divide, address arithmetic) and floating point, and sends at most one of them per cycle. Port 1 handles only simple integer work. Ports 2, 3 and 4 are dedicated to loads, store addresses and store data. Simple integer micro-ops go to port 1 first. They spill onto port 0 only when port 0 has nothing of its own to send. An entry is released on the edge at which it is dispatched. Rename receives a same-cycle accept that is all-or-nothing for the lanes it presents.

Top module: `uop_dispatch_sched`

## Requirements
- R1: After reset no dispatch valid is set and all entries are free, so a request on every allocation lane is accepted.
- R2: `alloc_accept` is high in the same cycle exactly when the number of free entries is at least the number of set `alloc_valid` bits. A refused request writes nothing. On acceptance, the lowest-numbered set lane takes the lowest-numbered free entry and the next set lane takes the next free entry.
- R3: An entry is dispatched only when both of its source-ready flags are set. An entry with a pending source is never dispatched.
- R4: A wakeup tag that matches a pending source on any wakeup bus sets that flag at the next edge, and the entry can be dispatched at the edge after that. A tag that matches a lane being allocated in the same cycle also counts.
- R5: Port 0 sends class 0 (complex integer) or class 2 (floating point) micro-ops, one per cycle, the oldest first.
- R6: Class 1 (simple integer) goes to port 1, the oldest first. The next-oldest eligible class 1 entry uses port 0 only in a cycle when no class 0 or class 2 entry is eligible.
- R7: Class 3 (load), class 4 (store address) and class 5 (store data) dispatch only on ports 2, 3 and 4 respectively, one per cycle each. Class codes 6 and 7 are not used.
- R8: Among eligible entries for one port, the one allocated earliest wins, whatever its index. In the same cycle, a lower lane counts as older than a higher lane.
- R9: At most five entries leave per cycle, no entry on two ports. `disp_valid[p]` and `disp_idx[4p+3:4p]` are registered: an entry that is eligible during a cycle appears on the outputs after the next edge.
- R10: A dispatched entry is freed at its dispatch edge, so `disp_valid` pulses for one cycle per entry. The freed entry can be accepted for allocation in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | LANES | Allocation request per lane |
| alloc_class | input | LANES*3 | Class code per lane |
| alloc_src1_tag | input | LANES*TAG_W | First source tag per lane |
| alloc_src1_rdy | input | LANES | First source already ready |
| alloc_src2_tag | input | LANES*TAG_W | Second source tag per lane |
| alloc_src2_rdy | input | LANES | Second source already ready |
| alloc_accept | output | 1 | Request accepted this cycle |
| wake_valid | input | WAKE_N | Wakeup bus valid |
| wake_tag | input | WAKE_N*TAG_W | Wakeup result tags |
| disp_valid | output | 5 | Dispatch valid per port |
| disp_idx | output | 5*IDX_W | Dispatched entry index per port |

## Verification
`alloc_accept` is combinational, so it is checked one nanosecond after the request is driven and well before the edge. An entry allocated with both sources ready shows up on `disp_valid`/`disp_idx` after the second rising edge following the request. A wakeup driven before edge W sets the flag at W and produces a dispatch after W+1. The bench drives every stimulus on a falling edge and checks outputs on the falling edge that matches these counts. Between stimuli it also checks the cycles in which nothing may leave, so an early or a late dispatch is reported as well as a wrong one.

// File: rtl/rs_sched_pkg.sv
package rs_sched_pkg;

  localparam int CLS_W     = 3;
  localparam int NUM_PORTS = 5;

  localparam int P_MAIN   = 0;
  localparam int P_SIMPLE = 1;
  localparam int P_LOAD   = 2;
  localparam int P_STA    = 3;
  localparam int P_STD    = 4;

  typedef enum logic [CLS_W-1:0] {
    UC_CPLX   = 3'd0,
    UC_SIMPLE = 3'd1,
    UC_FP     = 3'd2,
    UC_LOAD   = 3'd3,
    UC_STA    = 3'd4,
    UC_STD    = 3'd5
  } uop_class_e;

endpackage

// File: rtl/rs_free_pick.sv
// Finds free slots for the allocation lanes; all-or-nothing acceptance.
module rs_free_pick #(
  parameter int N     = 16,
  parameter int LANES = 2
) (
  input  logic [N-1:0]       busy,
  input  logic [LANES-1:0]   req,
  output logic [LANES*N-1:0] grant,
  output logic               accept
);

  always_comb begin
    logic [N-1:0] avail;
    logic [N-1:0] lowest;
    int unsigned  nfree;
    int unsigned  nreq;
    avail  = ~busy;
    nfree  = $countones(avail);
    nreq   = $countones(req);
    accept = (nfree >= nreq);
    grant  = '0;
    for (int l = 0; l < LANES; l++) begin
      lowest = avail & (~avail + 1'b1);
      if (req[l] && accept) begin
        grant[l*N +: N] = lowest;
        avail           = avail & ~lowest;
      end
    end
  end

endmodule

// File: rtl/rs_age_matrix.sv
// older[i*N+j] is set when entry i was allocated before entry j.
module rs_age_matrix #(
  parameter int N     = 16,
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LANES*N-1:0] alloc_oh,
  output logic [N*N-1:0]     older
);

  logic [N*N-1:0] older_d;
  logic [N-1:0]   fresh;

  always_comb begin
    fresh = '0;
    for (int l = 0; l < LANES; l++) fresh |= alloc_oh[l*N +: N];
  end

  always_comb begin
    logic v;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (i == j) begin
          v = 1'b0;
        end else if (fresh[j]) begin
          // existing entries are older than a newcomer; among newcomers lower lane wins
          v = !fresh[i];
          for (int m = 0; m < LANES; m++)
            for (int k = 0; k < LANES; k++)
              if (m < k && alloc_oh[m*N+i] && alloc_oh[k*N+j]) v = 1'b1;
        end else if (fresh[i]) begin
          v = 1'b0;
        end else begin
          v = older[i*N+j];
        end
        older_d[i*N+j] = v;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) older <= '0;
    else     older <= older_d;
  end

endmodule

// File: rtl/rs_oldest_pick.sv
// Selects the candidate that no other candidate is older than.
module rs_oldest_pick #(
  parameter  int N     = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     cand,
  input  logic [N*N-1:0]   older,
  output logic             found,
  output logic [N-1:0]     win,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    logic beaten;
    win = '0;
    idx = '0;
    for (int c = 0; c < N; c++) begin
      beaten = 1'b0;
      for (int j = 0; j < N; j++)
        if (cand[j] && older[j*N+c]) beaten = 1'b1;
      win[c] = cand[c] && !beaten;
    end
    for (int c = 0; c < N; c++)
      if (win[c]) idx = IDX_W'(c);
    found = |cand;
  end

endmodule

// File: rtl/uop_dispatch_sched.sv
module uop_dispatch_sched
  import rs_sched_pkg::*;
#(
  parameter  int ENTRIES = 16,
  parameter  int TAG_W   = 6,
  parameter  int LANES   = 2,
  parameter  int WAKE_N  = 2,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [LANES-1:0]           alloc_valid,
  input  logic [LANES*CLS_W-1:0]     alloc_class,
  input  logic [LANES*TAG_W-1:0]     alloc_src1_tag,
  input  logic [LANES-1:0]           alloc_src1_rdy,
  input  logic [LANES*TAG_W-1:0]     alloc_src2_tag,
  input  logic [LANES-1:0]           alloc_src2_rdy,
  output logic                       alloc_accept,
  input  logic [WAKE_N-1:0]          wake_valid,
  input  logic [WAKE_N*TAG_W-1:0]    wake_tag,
  output logic [NUM_PORTS-1:0]       disp_valid,
  output logic [NUM_PORTS*IDX_W-1:0] disp_idx
);

  localparam int N = ENTRIES;

  // entry state
  logic [N-1:0]             ent_valid_q;
  logic [N-1:0][CLS_W-1:0]  ent_cls_q;
  logic [N-1:0][TAG_W-1:0]  ent_tag1_q;
  logic [N-1:0][TAG_W-1:0]  ent_tag2_q;
  logic [N-1:0]             ent_rdy1_q;
  logic [N-1:0]             ent_rdy2_q;

  logic [N-1:0]             elig;
  logic [LANES*N-1:0]       grant;
  logic [N*N-1:0]           older;
  logic [N-1:0]             hit1, hit2;
  logic [LANES-1:0]         ahit1, ahit2;

  function automatic logic tag_seen(input logic [TAG_W-1:0]        t,
                                    input logic [WAKE_N-1:0]       wv,
                                    input logic [WAKE_N*TAG_W-1:0] wt);
    logic h;
    h = 1'b0;
    for (int w = 0; w < WAKE_N; w++)
      if (wv[w] && wt[w*TAG_W +: TAG_W] == t) h = 1'b1;
    return h;
  endfunction

  // ---------------- allocation ----------------
  rs_free_pick #(.N(N), .LANES(LANES)) u_free (
    .busy   (ent_valid_q),
    .req    (alloc_valid),
    .grant  (grant),
    .accept (alloc_accept)
  );

  rs_age_matrix #(.N(N), .LANES(LANES)) u_age (
    .clk      (clk),
    .rst      (rst),
    .alloc_oh (grant),
    .older    (older)
  );

  // ---------------- wakeup ----------------
  always_comb begin
    for (int i = 0; i < N; i++) begin
      hit1[i] = tag_seen(ent_tag1_q[i], wake_valid, wake_tag);
      hit2[i] = tag_seen(ent_tag2_q[i], wake_valid, wake_tag);
    end
    for (int l = 0; l < LANES; l++) begin
      ahit1[l] = tag_seen(alloc_src1_tag[l*TAG_W +: TAG_W], wake_valid, wake_tag);
      ahit2[l] = tag_seen(alloc_src2_tag[l*TAG_W +: TAG_W], wake_valid, wake_tag);
    end
  end

  assign elig = ent_valid_q & ent_rdy1_q & ent_rdy2_q;

  // ---------------- port eligibility ----------------
  logic [NUM_PORTS-1:0][N-1:0]     port_cand;
  logic [NUM_PORTS-1:0][N-1:0]     port_win;
  logic [NUM_PORTS-1:0]            port_found;
  logic [NUM_PORTS-1:0][IDX_W-1:0] port_idx;

  always_comb begin
    port_cand = '0;
    for (int i = 0; i < N; i++) begin
      case (ent_cls_q[i])
        UC_CPLX, UC_FP: port_cand[P_MAIN][i]   = elig[i];
        UC_SIMPLE:      port_cand[P_SIMPLE][i] = elig[i];
        UC_LOAD:        port_cand[P_LOAD][i]   = elig[i];
        UC_STA:         port_cand[P_STA][i]    = elig[i];
        UC_STD:         port_cand[P_STD][i]    = elig[i];
        default:        ;
      endcase
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    rs_oldest_pick #(.N(N)) u_pick (
      .cand  (port_cand[p]),
      .older (older),
      .found (port_found[p]),
      .win   (port_win[p]),
      .idx   (port_idx[p])
    );
  end

  // second-oldest simple micro-op, candidate for spilling onto port 0
  logic [N-1:0]     fb_cand, fb_win;
  logic             fb_found;
  logic [IDX_W-1:0] fb_idx;

  assign fb_cand = port_cand[P_SIMPLE] & ~port_win[P_SIMPLE];

  rs_oldest_pick #(.N(N)) u_pick_spill (
    .cand  (fb_cand),
    .older (older),
    .found (fb_found),
    .win   (fb_win),
    .idx   (fb_idx)
  );

  // ---------------- final selection ----------------
  logic [NUM_PORTS-1:0]            fin_found;
  logic [NUM_PORTS-1:0][IDX_W-1:0] fin_idx;
  logic [N-1:0]                    disp_oh;

  always_comb begin
    fin_found = port_found;
    fin_idx   = port_idx;
    disp_oh   = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (p != P_MAIN) disp_oh |= port_win[p];
    if (port_found[P_MAIN]) begin
      disp_oh |= port_win[P_MAIN];
    end else begin
      fin_found[P_MAIN] = fb_found;
      fin_idx[P_MAIN]   = fb_idx;
      disp_oh          |= fb_win;
    end
  end

  // ---------------- entry state update ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid_q <= '0;
      ent_rdy1_q  <= '0;
      ent_rdy2_q  <= '0;
      ent_cls_q   <= '0;
      ent_tag1_q  <= '0;
      ent_tag2_q  <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (ent_valid_q[i] && disp_oh[i]) begin
          ent_valid_q[i] <= 1'b0;
        end else if (ent_valid_q[i]) begin
          if (hit1[i]) ent_rdy1_q[i] <= 1'b1;
          if (hit2[i]) ent_rdy2_q[i] <= 1'b1;
        end
        for (int l = 0; l < LANES; l++) begin
          if (grant[l*N+i]) begin
            ent_valid_q[i] <= 1'b1;
            ent_cls_q[i]   <= alloc_class[l*CLS_W +: CLS_W];
            ent_tag1_q[i]  <= alloc_src1_tag[l*TAG_W +: TAG_W];
            ent_tag2_q[i]  <= alloc_src2_tag[l*TAG_W +: TAG_W];
            ent_rdy1_q[i]  <= alloc_src1_rdy[l] | ahit1[l];
            ent_rdy2_q[i]  <= alloc_src2_rdy[l] | ahit2[l];
          end
        end
      end
    end
  end

  // ---------------- registered dispatch outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= '0;
      disp_idx   <= '0;
    end else begin
      disp_valid <= fin_found;
      for (int p = 0; p < NUM_PORTS; p++)
        disp_idx[p*IDX_W +: IDX_W] <= fin_idx[p];
    end
  end

endmodule

// File: rtl/rs_sched_chk.sv
module rs_sched_chk
  import rs_sched_pkg::*;
#(
  parameter  int N     = 16,
  parameter  int LANES = 2,
  localparam int IDX_W = $clog2(N)
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_PORTS-1:0]       disp_valid,
  input logic [NUM_PORTS*IDX_W-1:0] disp_idx,
  input logic [N-1:0]               ent_valid,
  input logic [N-1:0]               elig,
  input logic [N-1:0][CLS_W-1:0]    ent_cls,
  input logic [LANES-1:0]           alloc_valid,
  input logic                       alloc_accept
);

  logic [NUM_PORTS-1:0][IDX_W-1:0] di;
  logic [N-1:0]                    prev_valid, prev_elig;
  logic [N-1:0][CLS_W-1:0]         prev_cls;
  logic                            prev_main, main_now;
  int                              prev_cnt, prev_add;

  assign di = disp_idx;

  always_comb begin
    main_now = 1'b0;
    for (int i = 0; i < N; i++)
      if (elig[i] && (ent_cls[i] == UC_CPLX || ent_cls[i] == UC_FP)) main_now = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_valid <= '0;
      prev_elig  <= '0;
      prev_cls   <= '0;
      prev_main  <= 1'b0;
      prev_cnt   <= 0;
      prev_add   <= 0;
    end else begin
      prev_valid <= ent_valid;
      prev_elig  <= elig;
      prev_cls   <= ent_cls;
      prev_main  <= main_now;
      prev_cnt   <= $countones(ent_valid);
      prev_add   <= alloc_accept ? $countones(alloc_valid) : 0;
    end
  end

  // R2: occupancy moves only by accepted allocations and dispatches
  assert_occupancy_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(ent_valid) + $countones(disp_valid) == prev_cnt + prev_add);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
    // R3: only occupied entries with both sources ready leave
    assert_ready_src_R3: assert property (@(posedge clk) disable iff (rst)
      disp_valid[p] |-> (prev_valid[di[p]] && prev_elig[di[p]]));
    for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_pair
      // R9: no entry on two ports in one cycle
      assert_unique_entry_R9: assert property (@(posedge clk) disable iff (rst)
        (disp_valid[p] && disp_valid[q]) |-> (di[p] != di[q]));
    end
  end

  // R5: port 0 carries complex, floating point or spilled simple work only
  assert_main_class_R5: assert property (@(posedge clk) disable iff (rst)
    disp_valid[P_MAIN] |-> (prev_cls[di[P_MAIN]] == UC_CPLX ||
                            prev_cls[di[P_MAIN]] == UC_FP ||
                            prev_cls[di[P_MAIN]] == UC_SIMPLE));

  // R6: simple work on port 0 only when port 0 had nothing of its own and port 1 is busy
  assert_spill_R6: assert property (@(posedge clk) disable iff (rst)
    (disp_valid[P_MAIN] && prev_cls[di[P_MAIN]] == UC_SIMPLE) |->
      (!prev_main && disp_valid[P_SIMPLE] && prev_cls[di[P_SIMPLE]] == UC_SIMPLE));

  // R6: port 1 carries simple work only
  assert_simple_port_R6: assert property (@(posedge clk) disable iff (rst)
    disp_valid[P_SIMPLE] |-> (prev_cls[di[P_SIMPLE]] == UC_SIMPLE));

  // R7: dedicated memory ports
  assert_load_port_R7: assert property (@(posedge clk) disable iff (rst)
    disp_valid[P_LOAD] |-> (prev_cls[di[P_LOAD]] == UC_LOAD));
  assert_sta_port_R7: assert property (@(posedge clk) disable iff (rst)
    disp_valid[P_STA] |-> (prev_cls[di[P_STA]] == UC_STA));
  assert_std_port_R7: assert property (@(posedge clk) disable iff (rst)
    disp_valid[P_STD] |-> (prev_cls[di[P_STD]] == UC_STD));

endmodule

bind uop_dispatch_sched rs_sched_chk #(.N(ENTRIES), .LANES(LANES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .disp_valid   (disp_valid),
  .disp_idx     (disp_idx),
  .ent_valid    (ent_valid_q),
  .elig         (elig),
  .ent_cls      (ent_cls_q),
  .alloc_valid  (alloc_valid),
  .alloc_accept (alloc_accept)
);

// File: tb/uop_dispatch_sched_bench.sv
module uop_dispatch_sched_bench;
  import rs_sched_pkg::*;

  localparam int TW = 6;

  typedef struct packed {
    logic [2:0]    cls;
    logic [TW-1:0] t1;
    logic          r1;
    logic [TW-1:0] t2;
    logic          r2;
  } lane_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    alloc_valid = '0;
  logic [5:0]    alloc_class = '0;
  logic [11:0]   alloc_src1_tag = '0;
  logic [1:0]    alloc_src1_rdy = '0;
  logic [11:0]   alloc_src2_tag = '0;
  logic [1:0]    alloc_src2_rdy = '0;
  logic          alloc_accept;
  logic [1:0]    wake_valid = '0;
  logic [11:0]   wake_tag = '0;
  logic [4:0]    disp_valid;
  logic [19:0]   disp_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  uop_dispatch_sched u_uop_dispatch_sched (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_class(alloc_class),
    .alloc_src1_tag(alloc_src1_tag), .alloc_src1_rdy(alloc_src1_rdy),
    .alloc_src2_tag(alloc_src2_tag), .alloc_src2_rdy(alloc_src2_rdy),
    .alloc_accept(alloc_accept),
    .wake_valid(wake_valid), .wake_tag(wake_tag),
    .disp_valid(disp_valid), .disp_idx(disp_idx)
  );

  function automatic lane_t mk(input logic [2:0] c, input logic [TW-1:0] t1, input logic r1,
                               input logic [TW-1:0] t2, input logic r2);
    lane_t x;
    x.cls = c; x.t1 = t1; x.r1 = r1; x.t2 = t2; x.r2 = r2;
    return x;
  endfunction

  lane_t NONE;
  initial NONE = '0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // drives a request at a falling edge, checks accept, and withdraws it after the next rising edge
  task automatic do_alloc(input logic [1:0] v, input lane_t a, input lane_t b,
                          input bit exp_acc, input string rq);
    alloc_valid    = v;
    alloc_class    = {b.cls, a.cls};
    alloc_src1_tag = {b.t1, a.t1};
    alloc_src1_rdy = {b.r1, a.r1};
    alloc_src2_tag = {b.t2, a.t2};
    alloc_src2_rdy = {b.r2, a.r2};
    #1;
    chk(alloc_accept == exp_acc, rq, "alloc_accept", int'(alloc_accept), int'(exp_acc));
    @(negedge clk);
    alloc_valid = '0;
  endtask

  task automatic do_wake(input logic [1:0] v, input logic [TW-1:0] ta, input logic [TW-1:0] tb);
    wake_valid = v;
    wake_tag   = {tb, ta};
    @(negedge clk);
    wake_valid = '0;
  endtask

  task automatic expect_disp(input logic [4:0] ev, input int e0, input int e1, input int e2,
                             input int e3, input int e4, input string rq);
    int e [5];
    e = '{e0, e1, e2, e3, e4};
    chk(disp_valid == ev, rq, "disp_valid", int'(disp_valid), int'(ev));
    for (int p = 0; p < 5; p++)
      if (ev[p] && disp_valid[p])
        chk(int'(disp_idx[p*4 +: 4]) == e[p], rq, $sformatf("disp_idx port%0d", p),
            int'(disp_idx[p*4 +: 4]), e[p]);
  endtask

  // R1
  task automatic t_reset();
    chk(disp_valid == 5'b0, "R1", "disp_valid after reset", int'(disp_valid), 0);
    alloc_valid = 2'b11;
    #1;
    chk(alloc_accept == 1'b1, "R1", "accept on empty pool", int'(alloc_accept), 1);
    alloc_valid = 2'b00;
    step();
  endtask

  // R9, R10: ready load leaves two edges after the request, for one cycle
  task automatic t_ready_load();
    do_alloc(2'b01, mk(UC_LOAD, 6'd1, 1'b1, 6'd2, 1'b1), NONE, 1'b1, "R2");
    expect_disp(5'b00000, 0, 0, 0, 0, 0, "R9");
    step();
    expect_disp(5'b00100, 0, 0, 0, 0, 0, "R9");
    step();
    expect_disp(5'b00000, 0, 0, 0, 0, 0, "R10");
  endtask

  // R3, R4: both sources must be woken, one per bus
  task automatic t_wait_wake();
    do_alloc(2'b01, mk(UC_SIMPLE, 6'd5, 1'b0, 6'd6, 1'b0), NONE, 1'b1, "R2");
    step();
    step();
    expect_disp(5'b00000, 0, 0, 0, 0, 0, "R3");
    do_wake(2'b01, 6'd5, 6'd0);
    step();
    expect_disp(5'b00000, 0, 0, 0, 0, 0, "R3");
    do_wake(2'b10, 6'd0, 6'd6);
    step();
    expect_disp(5'b00010, 0, 0, 0, 0, 0, "R4");
    step();
    expect_disp(5'b00000, 0, 0, 0, 0, 0, "R10");
  endtask

  // R4: wakeup in the same cycle as allocation
  task automatic t_bypass();
    wake_valid = 2'b01;
    wake_tag   = {6'd0, 6'd9};
    do_alloc(2'b01, mk(UC_STA, 6'd9, 1'b0, 6'd9, 1'b0), NONE, 1'b1, "R2");
    wake_valid = '0;
    step();
    expect_disp(5'b01000, 0, 0, 0, 0, 0, "R4");
    step();
    expect_disp(5'b00000, 0, 0, 0, 0, 0, "R4");
  endtask

  // R5, R8: complex and FP share port 0, lane 0 older
  task automatic t_port0_share();
    do_alloc(2'b11, mk(UC_CPLX, 6'd1, 1'b1, 6'd1, 1'b1),
                    mk(UC_FP,   6'd1, 1'b1, 6'd1, 1'b1), 1'b1, "R2");
    step();
    expect_disp(5'b00001, 0, 0, 0, 0, 0, "R5");
    step();
    expect_disp(5'b00001, 1, 0, 0, 0, 0, "R5");
    step();
    expect_disp(5'b00000, 0, 0, 0, 0, 0, "R5");
  endtask

  // R6: two simple micro-ops, the second spills onto port 0
  task automatic t_simple_spill();
    do_alloc(2'b11, mk(UC_SIMPLE, 6'd1, 1'b1, 6'd1, 1'b1),
                    mk(UC_SIMPLE, 6'd1, 1'b1, 6'd1, 1'b1), 1'b1, "R2");
    step();
    expect_disp(5'b00011, 1, 0, 0, 0, 0, "R6");
    step();
    expect_disp(5'b00000, 0, 0, 0, 0, 0, "R6");
  endtask

  // R6: no spill while port 0 has complex work
  task automatic t_no_spill();
    do_alloc(2'b11, mk(UC_CPLX,   6'd30, 1'b0, 6'd30, 1'b1),
                    mk(UC_SIMPLE, 6'd30, 1'b0, 6'd30, 1'b1), 1'b1, "R2");
    do_alloc(2'b01, mk(UC_SIMPLE, 6'd30, 1'b0, 6'd30, 1'b1), NONE, 1'b1, "R2");
    do_wake(2'b01, 6'd30, 6'd0);
    step();
    expect_disp(5'b00011, 0, 1, 0, 0, 0, "R6");
    step();
    expect_disp(5'b00010, 0, 2, 0, 0, 0, "R6");
    step();
    expect_disp(5'b00000, 0, 0, 0, 0, 0, "R6");
  endtask

  // R8, R10: older entry at higher index wins; freed slot reused next cycle
  task automatic t_age();
    do_alloc(2'b11, mk(UC_LOAD, 6'd50, 1'b0, 6'd50, 1'b1),
                    mk(UC_LOAD, 6'd51, 1'b0, 6'd51, 1'b1), 1'b1, "R2");
    do_wake(2'b01, 6'd50, 6'd0);
    step();
    expect_disp(5'b00100, 0, 0, 0, 0, 0, "R8");
    do_alloc(2'b01, mk(UC_LOAD, 6'd52, 1'b0, 6'd52, 1'b1), NONE, 1'b1, "R10");
    do_wake(2'b11, 6'd51, 6'd52);
    step();
    expect_disp(5'b00100, 0, 0, 1, 0, 0, "R8");
    step();
    expect_disp(5'b00100, 0, 0, 0, 0, 0, "R8");
    step();
    expect_disp(5'b00000, 0, 0, 0, 0, 0, "R8");
  endtask

  // R7, R9: all five ports in one cycle; lane 1 alone takes the lowest free slot
  task automatic t_five();
    do_alloc(2'b11, mk(UC_FP,   6'd60, 1'b0, 6'd60, 1'b0),
                    mk(UC_SIMPLE, 6'd60, 1'b0, 6'd60, 1'b0), 1'b1, "R2");
    do_alloc(2'b11, mk(UC_LOAD, 6'd60, 1'b0, 6'd60, 1'b0),
                    mk(UC_STA,  6'd60, 1'b0, 6'd60, 1'b0), 1'b1, "R2");
    do_alloc(2'b10, NONE, mk(UC_STD, 6'd60, 1'b0, 6'd60, 1'b0), 1'b1, "R2");
    step();
    expect_disp(5'b00000, 0, 0, 0, 0, 0, "R3");
    do_wake(2'b10, 6'd0, 6'd60);
    step();
    expect_disp(5'b11111, 0, 1, 2, 3, 4, "R9");
    step();
    expect_disp(5'b00000, 0, 0, 0, 0, 0, "R7");
  endtask

  // R2, R10: backpressure at full pool, reuse of the first freed slot
  task automatic t_full();
    lane_t w;
    w = mk(UC_LOAD, 6'd44, 1'b0, 6'd44, 1'b1);
    for (int k = 0; k < 7; k++) do_alloc(2'b11, w, w, 1'b1, "R2");
    do_alloc(2'b01, w, NONE, 1'b1, "R2");
    do_alloc(2'b11, w, w, 1'b0, "R2");
    do_alloc(2'b01, w, NONE, 1'b1, "R2");
    do_alloc(2'b10, NONE, w, 1'b0, "R2");
    expect_disp(5'b00000, 0, 0, 0, 0, 0, "R3");
    do_wake(2'b01, 6'd44, 6'd0);
    step();
    expect_disp(5'b00100, 0, 0, 0, 0, 0, "R8");
    do_alloc(2'b01, mk(UC_STD, 6'd1, 1'b1, 6'd1, 1'b1), NONE, 1'b1, "R10");
    expect_disp(5'b00100, 0, 0, 1, 0, 0, "R8");
    step();
    expect_disp(5'b10100, 0, 0, 2, 0, 0, "R10");
    for (int k = 3; k < 16; k++) begin
      step();
      expect_disp(5'b00100, 0, 0, k, 0, 0, "R2");
    end
    step();
    expect_disp(5'b00000, 0, 0, 0, 0, 0, "R2");
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step();
    t_reset();
    t_ready_load();
    t_wait_wake();
    t_bypass();
    t_port0_share();
    t_simple_spill();
    t_no_spill();
    t_age();
    t_five();
    t_full();
    step();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule